// File: doc/BRIEF.md
# Snoop Response Combiner

This block sits beside a snooping bus and merges the per-cache snoop answers for each address transaction. Every cache gives three signals for the current transaction: whether it holds a copy, whether its copy is modified, and whether its answer is final. The combiner ORs the copy and modified answers into one shared line and one dirty line. It raises a qualifier when those lines may be sampled, and it tells main memory either to return the block or to stand aside so that the owning cache can source it.

Two timing disciplines are available, and the mode is chosen per transaction. In fixed mode the answer is taken a set number of cycles after the address, and caches that are late count as clean and raise an error flag. In variable mode the answer waits for every cache. During that wait memory must treat the block as owned by some cache, so it may start its read but must not drive data yet.

Top module: `snp_combine`

## Requirements
- R1: After reset, and before any address transaction, every output is low.
- R2: When `snoop_valid_o` is high, `comb_shared_o` is the OR of the shared flags of every cache whose report was accepted for that transaction.
- R3: When `snoop_valid_o` is high, `comb_dirty_o` is the OR of the accepted dirty flags. While `snoop_valid_o` is low, both `comb_shared_o` and `comb_dirty_o` are low.
- R4: Suppose `var_mode_i` is 0 in the cycle where `addr_valid_i` is 1 (cycle c). Reports are then accepted in cycles c+1 to c+FIXED_DELAY, and `snoop_valid_o` rises in cycle c+FIXED_DELAY+1.
- R5: In fixed mode, a cache with no report by the deadline counts as not shared and not dirty, and `late_err_o` is high while that result is held. `late_err_o` never rises in variable mode.
- R6: If `var_mode_i` is 1 in the address cycle, the transaction has no deadline. `snoop_valid_o` rises in the cycle after the cycle in which the last outstanding cache's report is accepted.
- R7: `mem_supply_o` is high exactly while a result is held with `comb_dirty_o` low. `mem_inhibit_o` is high while a variable-mode transaction is unresolved, and also while a held result has the dirty line set. The two are never high together.
- R8: A cache's flags count only in a cycle where its own done bit is 1, and only its first such report in a transaction counts. Flags without done, and later repeats, do not change the result.
- R9: A result stays held until the next `addr_valid_i`. An `addr_valid_i` clears the held result and any partial collection, including one that is mid-flight, so `snoop_valid_o` is low in the cycle that follows it.
- R10: The mode is captured in the address cycle. Changes on `var_mode_i` during a transaction have no effect on it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| var_mode_i | input | 1 | 1 selects variable-latency collection for the transaction that starts this cycle |
| addr_valid_i | input | 1 | A new address transaction appears on the bus this cycle |
| snp_shared_i | input | NUM_CACHES | Per-cache: holds a copy |
| snp_dirty_i | input | NUM_CACHES | Per-cache: holds a modified copy |
| snp_done_i | input | NUM_CACHES | Per-cache: report is final this cycle |
| comb_shared_o | output | 1 | Combined shared line |
| comb_dirty_o | output | 1 | Combined dirty/inhibit line |
| snoop_valid_o | output | 1 | Combined lines may be sampled |
| mem_supply_o | output | 1 | Memory returns the block |
| mem_inhibit_o | output | 1 | Memory must hold back its data |
| late_err_o | output | 1 | Fixed-mode deadline missed by at least one cache |

## Verification
The combining is tried with reports that arrive all at once, reports spread one cache per cycle, and reports in which only some caches answer before a fixed deadline. These patterns separate a correct OR over accepted reports from logic that resolves too early, too late, or treats absent caches as dirty. Flags raised without done, and repeated reports, show whether acceptance is really gated and first-report-wins. Restarts in mid-transaction and mode toggles during collection check that state is cleared and that the mode is latched. A long run with random masks and modes is compared cycle by cycle against a behavioural model.

// File: rtl/snp_pkg.sv
package snp_pkg;

    typedef enum logic {
        MODE_FIXED = 1'b0,
        MODE_VAR   = 1'b1
    } snp_mode_e;

    typedef struct packed {
        logic shared;
        logic dirty;
        logic late;
    } snp_result_t;

endpackage

// File: rtl/snp_collect.sv
module snp_collect #(
    parameter int NUM_CACHES = 4
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  clear_i,
    input  logic                  accept_i,
    input  logic [NUM_CACHES-1:0] shared_i,
    input  logic [NUM_CACHES-1:0] dirty_i,
    input  logic [NUM_CACHES-1:0] done_i,
    output logic                  all_seen_o,
    output logic                  any_shared_o,
    output logic                  any_dirty_o
);

    typedef struct packed {
        logic [NUM_CACHES-1:0] seen;
        logic [NUM_CACHES-1:0] shr;
        logic [NUM_CACHES-1:0] drt;
    } col_t;

    col_t st_d, st_q;
    logic [NUM_CACHES-1:0] take;

    // A cache's report is taken only once per transaction.
    for (genvar i = 0; i < NUM_CACHES; i++) begin : g_take
        assign take[i] = accept_i & done_i[i] & ~st_q.seen[i];
    end

    always_comb begin
        st_d = st_q;
        if (clear_i) begin
            st_d = '0;
        end else begin
            for (int i = 0; i < NUM_CACHES; i++) begin
                if (take[i]) begin
                    st_d.seen[i] = 1'b1;
                    st_d.shr[i]  = shared_i[i];
                    st_d.drt[i]  = dirty_i[i];
                end
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    // Views that already include this cycle's accepted reports.
    assign all_seen_o   = &(st_q.seen | take);
    assign any_shared_o = |(st_q.shr | (take & shared_i));
    assign any_dirty_o  = |(st_q.drt | (take & dirty_i));

    // A recorded report is never withdrawn before the next clear.
    assert_seen_sticky_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !clear_i |=> ((st_q.seen & $past(st_q.seen)) == $past(st_q.seen)));

    // Flags of an already recorded cache are never overwritten.
    assert_first_report_kept_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !clear_i |=> (((st_q.shr ^ $past(st_q.shr)) | (st_q.drt ^ $past(st_q.drt)))
                      & $past(st_q.seen)) == '0);

endmodule

// File: rtl/snp_timer.sv
module snp_timer #(
    parameter int DELAY = 3
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clear_i,
    input  logic run_i,
    output logic expire_o
);

    localparam int CW = $clog2(DELAY + 1);
    localparam logic [CW-1:0] LAST = CW'(DELAY - 1);
    localparam logic [CW-1:0] TOP  = CW'(DELAY);

    logic [CW-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d = cnt_q;
        if (clear_i)                 cnt_d = '0;
        else if (run_i && cnt_q < TOP) cnt_d = cnt_q + 1'b1;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

    assign expire_o = run_i & (cnt_q == LAST);

    // Deadline fires on the DELAY-th running cycle only.
    assert_count_bounded_R4: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_q <= TOP);

endmodule

// File: rtl/snp_combine.sv
module snp_combine
    import snp_pkg::*;
#(
    parameter int NUM_CACHES  = 4,
    parameter int FIXED_DELAY = 3
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  var_mode_i,
    input  logic                  addr_valid_i,
    input  logic [NUM_CACHES-1:0] snp_shared_i,
    input  logic [NUM_CACHES-1:0] snp_dirty_i,
    input  logic [NUM_CACHES-1:0] snp_done_i,
    output logic                  comb_shared_o,
    output logic                  comb_dirty_o,
    output logic                  snoop_valid_o,
    output logic                  mem_supply_o,
    output logic                  mem_inhibit_o,
    output logic                  late_err_o
);

    typedef struct packed {
        logic        busy;
        snp_mode_e   mode;
        logic        valid;
        snp_result_t res;
    } ctl_t;

    ctl_t st_d, st_q;

    logic all_seen, any_shr, any_drt, tmr_expire, resolve;

    snp_collect #(.NUM_CACHES(NUM_CACHES)) u_collect (
        .clk          (clk),
        .rst_n        (rst_n),
        .clear_i      (addr_valid_i),
        .accept_i     (st_q.busy & ~addr_valid_i),
        .shared_i     (snp_shared_i),
        .dirty_i      (snp_dirty_i),
        .done_i       (snp_done_i),
        .all_seen_o   (all_seen),
        .any_shared_o (any_shr),
        .any_dirty_o  (any_drt)
    );

    snp_timer #(.DELAY(FIXED_DELAY)) u_timer (
        .clk      (clk),
        .rst_n    (rst_n),
        .clear_i  (addr_valid_i),
        .run_i    (st_q.busy & (st_q.mode == MODE_FIXED) & ~addr_valid_i),
        .expire_o (tmr_expire)
    );

    assign resolve = (st_q.mode == MODE_VAR) ? all_seen : tmr_expire;

    always_comb begin
        st_d = st_q;
        if (addr_valid_i) begin
            st_d.busy  = 1'b1;
            st_d.mode  = var_mode_i ? MODE_VAR : MODE_FIXED;
            st_d.valid = 1'b0;
            st_d.res   = '0;
        end else if (st_q.busy && resolve) begin
            st_d.busy       = 1'b0;
            st_d.valid      = 1'b1;
            st_d.res.shared = any_shr;
            st_d.res.dirty  = any_drt;
            st_d.res.late   = (st_q.mode == MODE_FIXED) & ~all_seen;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '{busy: 1'b0, mode: MODE_FIXED, valid: 1'b0, res: '0};
        end else begin
            st_q <= st_d;
        end
    end

    assign snoop_valid_o = st_q.valid;
    assign comb_shared_o = st_q.valid & st_q.res.shared;
    assign comb_dirty_o  = st_q.valid & st_q.res.dirty;
    assign late_err_o    = st_q.valid & st_q.res.late;
    assign mem_supply_o  = st_q.valid & ~st_q.res.dirty;
    assign mem_inhibit_o = (st_q.busy & (st_q.mode == MODE_VAR))
                         | (st_q.valid & st_q.res.dirty);

    assert_fixed_on_deadline_R4: assert property (@(posedge clk) disable iff (!rst_n)
        ($rose(snoop_valid_o) && st_q.mode == MODE_FIXED) |-> $past(tmr_expire));

    assert_var_after_last_R6: assert property (@(posedge clk) disable iff (!rst_n)
        ($rose(snoop_valid_o) && st_q.mode == MODE_VAR) |-> $past(all_seen));

    assert_late_fixed_only_R5: assert property (@(posedge clk) disable iff (!rst_n)
        late_err_o |-> (st_q.mode == MODE_FIXED));

    assert_dirty_stands_down_R7: assert property (@(posedge clk) disable iff (!rst_n)
        comb_dirty_o |-> (mem_inhibit_o && !mem_supply_o));

    assert_restart_clears_R9: assert property (@(posedge clk) disable iff (!rst_n)
        $past(addr_valid_i) |-> !snoop_valid_o);

endmodule

// File: tb/snp_combine_test.sv
`timescale 1ns/1ps
module snp_combine_test;

    localparam int N = 4;
    localparam int D = 3;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic var_mode = 1'b0, addr_valid = 1'b0;
    logic [N-1:0] sh = '0, dt = '0, dn = '0;
    logic o_sh, o_dt, o_vld, o_sup, o_inh, o_late;

    always #2.5 clk = ~clk;

    snp_combine #(.NUM_CACHES(N), .FIXED_DELAY(D)) uut (
        .clk(clk), .rst_n(rst_n), .var_mode_i(var_mode), .addr_valid_i(addr_valid),
        .snp_shared_i(sh), .snp_dirty_i(dt), .snp_done_i(dn),
        .comb_shared_o(o_sh), .comb_dirty_o(o_dt), .snoop_valid_o(o_vld),
        .mem_supply_o(o_sup), .mem_inhibit_o(o_inh), .late_err_o(o_late)
    );

    int checks = 0, fails = 0;
    bit finished = 0;
    string cur_req = "R1";

    // Behavioural reference model
    bit m_busy, m_var, m_valid, m_sh, m_dt, m_late, a_sh, a_dt;
    int m_cnt;
    bit m_seen [N];

    always @(posedge clk) begin
        if (!rst_n) begin
            m_busy = 0; m_var = 0; m_valid = 0; m_sh = 0; m_dt = 0; m_late = 0;
            a_sh = 0; a_dt = 0; m_cnt = 0;
            for (int i = 0; i < N; i++) m_seen[i] = 0;
        end else if (addr_valid) begin
            m_busy = 1; m_var = var_mode; m_valid = 0; m_sh = 0; m_dt = 0; m_late = 0;
            a_sh = 0; a_dt = 0; m_cnt = 0;
            for (int i = 0; i < N; i++) m_seen[i] = 0;
        end else if (m_busy) begin
            bit all;
            for (int i = 0; i < N; i++) begin
                if (dn[i] && !m_seen[i]) begin
                    m_seen[i] = 1;
                    a_sh = a_sh | sh[i];
                    a_dt = a_dt | dt[i];
                end
            end
            m_cnt++;
            all = 1;
            for (int i = 0; i < N; i++) if (!m_seen[i]) all = 0;
            if (m_var ? all : (m_cnt == D)) begin
                m_busy = 0; m_valid = 1; m_sh = a_sh; m_dt = a_dt;
                m_late = !m_var && !all;
            end
        end
    end

    task automatic check(string req, string name, logic act, logic exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s %s: actual %b expected %b at %0t", req, name, act, exp, $time);
        end
    endtask

    always @(negedge clk) begin
        if (rst_n && !finished) begin
            check(cur_req, "snoop_valid", o_vld, m_valid);
            check("R2", "comb_shared", o_sh, m_valid & m_sh);
            check("R3", "comb_dirty", o_dt, m_valid & m_dt);
            check("R5", "late_err", o_late, m_valid & m_late);
            check("R7", "mem_supply", o_sup, m_valid & !m_dt);
            check("R7", "mem_inhibit", o_inh, (m_busy & m_var) | (m_valid & m_dt));
        end
    end

    task automatic drv(logic a, logic v, logic [N-1:0] d, logic [N-1:0] s, logic [N-1:0] w);
        @(posedge clk); #1;
        addr_valid = a; var_mode = v; dn = d; sh = s; dt = w;
    endtask

    task automatic idle(int n);
        for (int k = 0; k < n; k++) drv(0, var_mode, '0, '0, '0);
    endtask

    task automatic finish_run();
        if (!finished) begin
            finished = 1;
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    endtask

    initial begin
        #(5.0 * 150000);
        checks++; fails++;
        $display("FAIL watchdog: actual hung expected done");
        finish_run();
    end

    initial begin
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;
        #2;
        // R1: reset state
        check("R1", "valid after reset", o_vld, 0);
        check("R1", "supply after reset", o_sup, 0);
        check("R1", "inhibit after reset", o_inh, 0);
        idle(2);

        // R4/R2: fixed mode, all caches answer, two shared
        cur_req = "R4";
        drv(1, 0, '0, '0, '0);
        drv(0, 0, 4'b0011, 4'b0001, 4'b0000);
        drv(0, 0, 4'b1100, 4'b0100, 4'b0000);
        drv(0, 0, '0, '0, '0); #2;
        check("R4", "valid before deadline", o_vld, 0);
        drv(0, 0, '0, '0, '0); #2;
        check("R4", "valid at deadline", o_vld, 1);
        check("R2", "shared from two caches", o_sh, 1);
        check("R7", "supply on clean", o_sup, 1);
        idle(2);
        check("R9", "result held", o_vld, 1);

        // R5/R3: fixed, cache 3 never answers, cache 1 dirty
        cur_req = "R5";
        drv(1, 0, '0, '0, '0);
        drv(0, 0, 4'b0010, 4'b0010, 4'b0010);
        drv(0, 0, 4'b0101, 4'b0000, 4'b0000);
        drv(0, 0, '0, '0, '0);
        drv(0, 0, 4'b1000, 4'b1000, 4'b1000); #2;
        check("R5", "late flagged", o_late, 1);
        check("R3", "dirty combined", o_dt, 1);
        check("R7", "memory stands down", o_inh, 1);
        idle(2);

        // R6: variable, staggered reports beyond fixed delay
        cur_req = "R6";
        drv(1, 1, '0, '0, '0); #2;
        drv(0, 1, 4'b0001, 4'b0001, 4'b0000);
        idle(3);
        drv(0, 1, 4'b0010, 4'b0000, 4'b0000);
        drv(0, 1, 4'b0100, 4'b0000, 4'b0000); #2;
        check("R7", "inhibit while pending", o_inh, 1);
        drv(0, 1, 4'b1000, 4'b0000, 4'b0000); #2;
        check("R6", "not valid in last report cycle", o_vld, 0);
        drv(0, 1, '0, '0, '0); #2;
        check("R6", "valid after last report", o_vld, 1);
        check("R5", "no late in variable mode", o_late, 0);
        idle(2);

        // R8: flags without done and repeat reports are ignored
        cur_req = "R8";
        drv(1, 1, '0, '0, '0);
        drv(0, 1, 4'b0000, 4'b1111, 4'b1111);
        drv(0, 1, 4'b0001, 4'b0000, 4'b0000);
        drv(0, 1, 4'b0001, 4'b0001, 4'b0001);
        drv(0, 1, 4'b1110, 4'b0000, 4'b0000);
        drv(0, 1, '0, '0, '0); #2;
        check("R8", "ignored flags not shared", o_sh, 0);
        check("R8", "ignored flags not dirty", o_dt, 0);
        idle(1);

        // R9: restart mid-flight; R10: mode toggle during transaction
        cur_req = "R9";
        drv(1, 0, '0, '0, '0);
        drv(0, 0, 4'b0001, 4'b0000, 4'b0001);
        drv(1, 1, '0, '0, '0); #2;
        check("R9", "restart clears", o_vld, 0);
        cur_req = "R10";
        drv(0, 0, 4'b1111, 4'b0000, 4'b0000); #2;
        check("R10", "mode latched variable", o_inh, 1);
        drv(0, 0, '0, '0, '0); #2;
        check("R10", "resolved clean", o_sup, 1);
        check("R9", "first transaction dirty dropped", o_dt, 0);
        idle(2);

        // Random transactions against the model
        cur_req = "R2";
        for (int t = 0; t < 80; t++) begin
            logic v;
            v = 1'($urandom);
            drv(1, v, '0, '0, '0);
            for (int c = 0; c < 7; c++) begin
                logic [N-1:0] rd;
                rd = (c == 6) ? '1 : N'($urandom);
                drv(0, 1'($urandom), rd, N'($urandom), N'($urandom & $urandom));
            end
            idle(1);
        end
        idle(2);
        finish_run();
    end

endmodule